// File: doc/BRIEF.md
# I2C Wait and Interrupt Timing Controller

This block decides, byte by byte, when an I2C interface stretches the serial clock and when it raises its transfer interrupt. It counts falling edges of the serial clock inside each nine-edge byte frame (eight data bits plus the acknowledge bit). At the chosen edge it raises a clock-hold request, which the pin driver turns into SCL held low, and it emits a one-cycle interrupt. In master mode the hold stops its own clock generation. In slave mode the hold stalls the remote master until software releases it.

The wait point is normally chosen by a software select bit: the last data edge or the acknowledge edge. During an address byte the select bit is overridden. A master always waits on the acknowledge edge. A slave that recognises its own address waits on the acknowledge edge, after it has driven the acknowledge. A slave that recognises an extension code waits on the last data edge. Software ends a wait by writing a self-clearing release bit. A separate enable lets a detected stop condition raise the interrupt. A master enable silences the whole block.

All inputs are synchronous to one system clock. Serial clock falling edges, start conditions and stop conditions arrive as one-cycle strobes from the neighbouring shifter.

Top module: `i2c_wait_ctl`

## Requirements
- R1: While reset is high and on the cycle after it, hold_scl, irq and rel_busy are all 0.
- R2: In a data byte with wait_sel latched as 0, hold_scl and irq rise on the cycle after the 8th scl_fall strobe of the byte, and hold_scl stays 0 for edges 1 to 7.
- R3: In a data byte with wait_sel latched as 1, hold_scl does not rise at the 8th edge and rises on the cycle after the 9th scl_fall strobe.
- R4: wait_sel is sampled at the first scl_fall of each byte. A change later in the byte has no effect until the next byte.
- R5: In an address byte (addr_phase=1) with is_master=1, the wait is placed at the 9th edge whatever wait_sel holds.
- R6: In an address byte with is_master=0, ext_code=1 places the wait at the 8th edge and takes priority over addr_match. Otherwise addr_match=1 places it at the 9th edge. With neither set, no wait and no interrupt occur in that byte.
- R7: irq is a one-cycle pulse. A wait-induced pulse comes on the same cycle that hold_scl rises.
- R8: A one-cycle rel_wr pulse while hold_scl=1 makes rel_busy read 1 on the next cycle. On the cycle after that, hold_scl and rel_busy are both 0.
- R9: A rel_wr pulse while hold_scl=0 leaves hold_scl at 0, and rel_busy returns to 0 one cycle after it reads 1.
- R10: A stop_det strobe gives an irq pulse on the next cycle only when stop_ie=1 (and en=1). With stop_ie=0 it gives none.
- R11: A start_det or stop_det strobe returns the edge count to zero, so the next wait is counted from the first edge after it. The count also returns to zero after the 9th edge.
- R12: While en=0, hold_scl, irq and rel_busy stay 0 and the edge count is cleared, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable; 0 quiets and clears the block |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| wait_sel | input | 1 | Wait point select: 0 = 8th edge, 1 = 9th edge |
| rel_wr | input | 1 | Software write of 1 to the wait-release bit |
| stop_ie | input | 1 | Allow interrupt on stop condition |
| scl_fall | input | 1 | One-cycle strobe per serial clock falling edge |
| start_det | input | 1 | One-cycle strobe on start or repeated start |
| stop_det | input | 1 | One-cycle strobe on stop condition |
| addr_phase | input | 1 | Current byte is an address byte |
| addr_match | input | 1 | Slave recognised its own address |
| ext_code | input | 1 | Slave recognised an extension code |
| hold_scl | output | 1 | Request to hold the serial clock low (wait) |
| irq | output | 1 | One-cycle transfer interrupt pulse |
| rel_busy | output | 1 | Readback of the self-clearing release bit |

## Verification
The hardest situation to reach is a change to the wait-point choice in the middle of a frame. This covers wait_sel flipping after the first edge of a byte and a start strobe arriving part-way through a byte. Only a precise count of falling edges relative to the byte boundary shows whether the block used the latched or the live value. Directed sequences place these changes at chosen edge numbers. A long run with seeded random strobes then mixes roles, address phases, starts, stops and release writes, and a cycle model in the bench predicts every output.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  // where in the frame the current byte waits
  typedef enum logic [1:0] {
    WP_NONE  = 2'd0,
    WP_DATA  = 2'd1,   // last data edge
    WP_FRAME = 2'd2    // acknowledge edge
  } wait_pt_e;
endpackage

// File: rtl/i2cw_frame_cnt.sv
module i2cw_frame_cnt #(
  parameter int FRAME_BITS = 9,
  parameter int CW = $clog2(FRAME_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_fall,
  input  logic frame_rst,
  output logic first_edge,
  output logic data_end,
  output logic frame_end
);
  localparam logic [CW-1:0] LAST_DATA = CW'(FRAME_BITS - 2);
  localparam logic [CW-1:0] LAST_EDGE = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          fall_ok;

  assign fall_ok    = scl_fall && !frame_rst;
  assign first_edge = fall_ok && (cnt_q == '0);
  assign data_end   = fall_ok && (cnt_q == LAST_DATA);
  assign frame_end  = fall_ok && (cnt_q == LAST_EDGE);

  always_ff @(posedge clk) begin
    if (rst || !en || frame_rst) begin
      cnt_q <= '0;
    end else if (fall_ok) begin
      if (cnt_q == LAST_EDGE) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cw_point_sel.sv
module i2cw_point_sel
  import i2cw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     first_edge,
  input  logic     wait_sel,
  input  logic     addr_phase,
  input  logic     is_master,
  input  logic     addr_match,
  input  logic     ext_code,
  output wait_pt_e point
);
  logic sel_q;
  logic sel_use;

  // the select bit is frozen for a byte at its first edge
  assign sel_use = first_edge ? wait_sel : sel_q;

  always_ff @(posedge clk) begin
    if (rst || !en)      sel_q <= 1'b0;
    else if (first_edge) sel_q <= wait_sel;
  end

  always_comb begin
    if (addr_phase) begin
      if (is_master)       point = WP_FRAME;
      else if (ext_code)   point = WP_DATA;
      else if (addr_match) point = WP_FRAME;
      else                 point = WP_NONE;
    end else begin
      point = sel_use ? WP_FRAME : WP_DATA;
    end
  end
endmodule

// File: rtl/i2cw_hold_ctl.sv
module i2cw_hold_ctl
  import i2cw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  wait_pt_e point,
  input  logic     data_end,
  input  logic     frame_end,
  input  logic     rel_wr,
  input  logic     stop_det,
  input  logic     stop_ie,
  output logic     hold_scl,
  output logic     irq,
  output logic     rel_busy
);
  logic wait_set;
  logic stop_irq;

  assign wait_set = ((point == WP_DATA)  && data_end) ||
                    ((point == WP_FRAME) && frame_end);
  assign stop_irq = stop_det && stop_ie;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_scl <= 1'b0;
      irq      <= 1'b0;
      rel_busy <= 1'b0;
    end else begin
      irq      <= wait_set || stop_irq;
      rel_busy <= rel_wr;
      if (wait_set)      hold_scl <= 1'b1;
      else if (rel_busy) hold_scl <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_wait_ctl.sv
module i2c_wait_ctl
  import i2cw_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic is_master,
  input  logic wait_sel,
  input  logic rel_wr,
  input  logic stop_ie,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic ext_code,
  output logic hold_scl,
  output logic irq,
  output logic rel_busy
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic     first_edge;
  logic     data_end;
  logic     frame_end;
  wait_pt_e point;

  i2cw_frame_cnt #(.FRAME_BITS(FRAME_BITS), .CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .scl_fall   (scl_fall),
    .frame_rst  (start_det || stop_det),
    .first_edge (first_edge),
    .data_end   (data_end),
    .frame_end  (frame_end)
  );

  i2cw_point_sel u_sel (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .first_edge (first_edge),
    .wait_sel   (wait_sel),
    .addr_phase (addr_phase),
    .is_master  (is_master),
    .addr_match (addr_match),
    .ext_code   (ext_code),
    .point      (point)
  );

  i2cw_hold_ctl u_hold (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .point     (point),
    .data_end  (data_end),
    .frame_end (frame_end),
    .rel_wr    (rel_wr),
    .stop_det  (stop_det),
    .stop_ie   (stop_ie),
    .hold_scl  (hold_scl),
    .irq       (irq),
    .rel_busy  (rel_busy)
  );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic rel_wr,
  input logic stop_ie,
  input logic stop_det,
  input logic hold_scl,
  input logic irq,
  input logic rel_busy
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!hold_scl && !irq && !rel_busy));

  // R7
  irq_with_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_scl) |-> irq);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> (!irq || $past(stop_det)));

  // R8
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_scl) |-> ($past(rel_busy) || !$past(en)));

  // R9
  rel_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
    rel_busy |=> (!rel_busy || $past(rel_wr)));

  // R10
  stop_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (en && stop_det && stop_ie) |=> irq);

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hold_scl && !irq && !rel_busy));
endmodule

bind i2c_wait_ctl i2cw_chk u_chk (.*);

// File: tb/sim_i2c_wait_ctl.sv
`timescale 1ns/1ps
module sim_i2c_wait_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, is_master = 1'b0, wait_sel = 1'b0, rel_wr = 1'b0;
  logic stop_ie = 1'b0, scl_fall = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic addr_phase = 1'b0, addr_match = 1'b0, ext_code = 1'b0;
  logic hold_scl, irq, rel_busy;

  always #10 clk = ~clk;

  i2c_wait_ctl u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // bench model state
  int m_cnt = 0;
  bit m_sel = 0, m_hold = 0, m_irq = 0, m_rel = 0;

  function automatic int target(bit sel_use);
    if (addr_phase) begin
      if (is_master)  return 9;
      if (ext_code)   return 8;
      if (addr_match) return 9;
      return 0;
    end
    return sel_use ? 9 : 8;
  endfunction

  task automatic model_step();
    bit set, fr, sel_use;
    if (rst || !en) begin
      m_cnt = 0; m_sel = 0; m_hold = 0; m_irq = 0; m_rel = 0;
      return;
    end
    fr  = start_det || stop_det;
    set = 0;
    sel_use = (m_cnt == 0) ? wait_sel : m_sel;
    if (scl_fall && !fr) set = ((m_cnt + 1) == target(sel_use));
    m_irq  = set || (stop_det && stop_ie);
    m_hold = set ? 1'b1 : (m_rel ? 1'b0 : m_hold);
    m_rel  = rel_wr;
    if (scl_fall && !fr && m_cnt == 0) m_sel = wait_sel;
    if (fr) m_cnt = 0;
    else if (scl_fall) m_cnt = (m_cnt == 8) ? 0 : m_cnt + 1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " model hold"}, hold_scl, m_hold);
    chk({tag, " model irq"},  irq,      m_irq);
    chk({tag, " model rel"},  rel_busy, m_rel);
  endtask

  task automatic falls(int n);
    for (int i = 0; i < n; i++) begin
      scl_fall = 1; tick(); scl_fall = 0; tick();
    end
  endtask

  task automatic one_fall_check(string req, logic exp_hold);
    scl_fall = 1; tick(); scl_fall = 0;
    chk(req, hold_scl, exp_hold);
    chk(req, irq, exp_hold);
    tick();
  endtask

  task automatic release_wait();
    rel_wr = 1; tick(); rel_wr = 0; tick();
  endtask

  task automatic start_byte();
    start_det = 1; tick(); start_det = 0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(); tick();
    // R1 reset state
    tag = "R1";
    chk("R1 hold", hold_scl, 0); chk("R1 irq", irq, 0); chk("R1 rel", rel_busy, 0);
    rst = 0; tick();
    chk("R1 after reset", hold_scl, 0);

    // R2 data byte, 8th edge
    tag = "R2"; en = 1; wait_sel = 0; start_byte();
    falls(7);
    chk("R2 no wait before 8th", hold_scl, 0);
    one_fall_check("R2 wait at 8th", 1);
    // R7 pulse is single cycle, hold stays
    chk("R7 irq one cycle", irq, 0);
    chk("R7 hold kept", hold_scl, 1);

    // R8 release
    tag = "R8"; rel_wr = 1; tick(); rel_wr = 0;
    chk("R8 rel reads 1", rel_busy, 1);
    chk("R8 hold still 1", hold_scl, 1);
    tick();
    chk("R8 hold released", hold_scl, 0);
    chk("R8 rel self-cleared", rel_busy, 0);

    // R11 9th edge wraps, R3 next byte uses 9th
    tag = "R3"; one_fall_check("R11 no wait at 9th when sel 0", 0);
    wait_sel = 1; falls(7);
    one_fall_check("R3 no wait at 8th", 0);
    one_fall_check("R3 wait at 9th", 1);
    release_wait();

    // R4 mid-byte change ignored
    tag = "R4"; falls(1); wait_sel = 0; falls(6);
    one_fall_check("R4 latched sel, no wait at 8th", 0);
    one_fall_check("R4 latched sel, wait at 9th", 1);
    release_wait();

    // R5 master address byte ignores wait_sel=0
    tag = "R5"; wait_sel = 0; is_master = 1; addr_phase = 1; start_byte();
    falls(7);
    one_fall_check("R5 master addr no wait at 8th", 0);
    one_fall_check("R5 master addr wait at 9th", 1);
    release_wait();

    // R6 slave address variants
    tag = "R6"; is_master = 0; addr_match = 1; start_byte();
    falls(7);
    one_fall_check("R6 match no wait at 8th", 0);
    one_fall_check("R6 match wait at 9th", 1);
    release_wait();
    ext_code = 1; start_byte(); falls(7);
    one_fall_check("R6 ext wait at 8th", 1);
    release_wait();
    ext_code = 0; addr_match = 0; start_byte(); falls(8);
    one_fall_check("R6 unaddressed no wait", 0);
    addr_phase = 0;

    // R9 release with no wait
    tag = "R9"; rel_wr = 1; tick(); rel_wr = 0;
    chk("R9 rel reads 1", rel_busy, 1);
    tick();
    chk("R9 rel back to 0", rel_busy, 0);
    chk("R9 hold untouched", hold_scl, 0);

    // R10 stop interrupt
    tag = "R10"; stop_ie = 1; stop_det = 1; tick(); stop_det = 0;
    chk("R10 stop irq enabled", irq, 1);
    tick();
    stop_ie = 0; stop_det = 1; tick(); stop_det = 0;
    chk("R10 stop irq disabled", irq, 0);
    tick();

    // R11 restart mid-byte recounts
    tag = "R11"; wait_sel = 0; start_byte(); falls(3); start_byte(); falls(7);
    chk("R11 no wait 7 after restart", hold_scl, 0);
    one_fall_check("R11 wait at 8th after restart", 1);
    release_wait();

    // R12 disabled
    tag = "R12"; en = 0; start_byte(); falls(9);
    chk("R12 no hold", hold_scl, 0);
    rel_wr = 1; stop_ie = 1; stop_det = 1; tick();
    rel_wr = 0; stop_det = 0;
    chk("R12 no rel", rel_busy, 0);
    chk("R12 no irq", irq, 0);
    en = 1; start_byte();

    // random mix
    tag = "R2/R3/R6/R7 random";
    for (int c = 0; c < 6000; c++) begin
      start_det = 0; stop_det = 0; scl_fall = 0;
      case ($urandom_range(99))
        0: start_det = 1;
        1: stop_det = 1;
        default: scl_fall = ($urandom_range(99) < 40);
      endcase
      rel_wr = ($urandom_range(99) < 8);
      if ($urandom_range(99) < 5) wait_sel = ~wait_sel;
      if ($urandom_range(99) < 3) stop_ie = ~stop_ie;
      if ($urandom_range(99) < 4) begin
        addr_phase = $urandom_range(1); is_master = $urandom_range(1);
        addr_match = $urandom_range(1); ext_code = $urandom_range(1);
      end
      en = ($urandom_range(199) != 0);
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule